// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Parity and Stop Checks

This block turns an asynchronous serial line back into bytes. It does not divide the clock itself. A separate divider supplies a one-cycle strobe at sixteen times the bit rate, for example one pulse every 27 cycles of a 50 MHz clock for 115200 baud. The receiver passes the line through a short synchronizer and waits for a high-to-low transition observed between two strobes. From that point it counts strobes within each bit and samples the line near the centre of every bit.

A frame has these parts, in order: a low start bit, eight data bits with the least significant bit first, an even-parity bit and a high stop bit. The receiver checks the start bit again at its centre, so that a short low glitch does not start a frame. It accumulates parity while the data bits arrive, compares that parity in the slot of the parity bit, and tests the stop bit. The byte and both error flags are then presented together with a data-ready flag, which stays set until the consumer pulses an acknowledge.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is asserted, and after it is released, `rx_byte` is 0, `par_err` and `frm_err` are 0 and `byte_rdy` is 0 until the first frame completes.
- R2: A frame starts only when two consecutive strobes see the synchronized line go from high to low. A line that stays low after a frame starts no new frame.
- R3: The start bit is sampled again at the ninth strobe after detection. If the line is high at that point, the frame is dropped and the outputs and `byte_rdy` keep their values.
- R4: The eight data bits are sampled at the centre of each bit, the first one received going to bit 0 of `rx_byte`.
- R5: Parity is even, so the parity bit equals the XOR of the data bits. Byte 0x52 carries a parity bit of 1 and byte 0x53 carries a parity bit of 0. `par_err` is 1 exactly when the received parity bit differs from that XOR.
- R6: `frm_err` is 1 exactly when the line is low at the centre-of-stop-bit sample.
- R7: `rx_byte`, `par_err`, `frm_err` and the rise of `byte_rdy` all update in the single clock that follows the strobe sampling the middle of the stop bit. None of them updates earlier.
- R8: `byte_rdy` stays high until a cycle with `rd_ack` high, and is low on the next clock. A completing frame in the same cycle as `rd_ack` takes priority and leaves `byte_rdy` high.
- R9: `rx_byte` and both flags change only when a frame completes. `rd_ack` does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| rd_ack | input | 1 | One-cycle acknowledge that clears data-ready |
| rx_byte | output | 8 | Last received byte |
| par_err | output | 1 | Parity mismatch of the last frame |
| frm_err | output | 1 | Stop bit found low in the last frame |
| byte_rdy | output | 1 | A frame has completed and has not been acknowledged |

## Verification
The bench keeps the line aligned with the strobe. Each bit lasts 16 strobes, and the falling edge of the start bit is seen within about two strobes. The stop-bit sample therefore falls roughly 170 strobes after the start edge, and the results follow one clock later, well inside the stop bit. To keep to that timing, the bench reads `byte_rdy` as still low once the parity bit has been driven. It then reads the byte and flags, with `byte_rdy` high, once the whole stop bit has been driven. An acknowledge takes effect on the next clock, so the bench samples one full cycle after the pulse. A dropped glitch and a line held low are each given more than a full frame time before the bench checks that nothing was published.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Receiver sequencing: waiting for a start edge, or walking bit slots.
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic clear_i,
  input  logic run_i,
  output logic bit_tick_o
);

  localparam int             CW   = $clog2(OVS);
  localparam logic [CW-1:0]  MID  = CW'(OVS / 2);
  localparam logic [CW-1:0]  LAST = CW'(OVS - 1);

  logic [CW-1:0] sub_q, sub_d;

  // Sub-bit strobe counter; cleared at the start edge, advanced per strobe.
  always_comb begin
    sub_d = sub_q;
    if (clear_i) begin
      sub_d = '0;
    end else if (run_i && os_tick) begin
      sub_d = (sub_q == LAST) ? '0 : sub_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

  // Centre-of-bit sample point.
  assign bit_tick_o = run_i & os_tick & (sub_q == MID);

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 line_i,
  input  logic                 bit_tick_i,
  output logic                 start_o,
  output logic                 busy_o,
  output logic                 pub_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 par_err_o,
  output logic                 frm_err_o
);

  localparam int            SLOTS     = DATA_BITS + 3;
  localparam int            SW        = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST_DATA = SW'(DATA_BITS);
  localparam logic [SW-1:0] PAR_SLOT  = SW'(DATA_BITS + 1);

  rx_state_e              state_q, state_d;
  logic [SW-1:0]          slot_q, slot_d;
  logic [DATA_BITS-1:0]   shift_q, shift_d;
  logic                   acc_q, acc_d;
  logic                   pbad_q, pbad_d;
  logic                   prev_q, prev_d;
  logic [DATA_BITS-1:0]   data_q, data_d;
  logic                   perr_q, perr_d;
  logic                   ferr_q, ferr_d;
  logic                   start_w, pub_w;

  // Falling edge between two consecutive strobes, only while idle.
  assign start_w = os_tick & (state_q == RX_IDLE) & prev_q & ~line_i;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    shift_d = shift_q;
    acc_d   = acc_q;
    pbad_d  = pbad_q;
    prev_d  = prev_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    pub_w   = 1'b0;

    if (os_tick) prev_d = line_i;

    unique case (state_q)
      RX_IDLE: begin
        if (start_w) begin
          state_d = RX_BUSY;
          slot_d  = '0;
          acc_d   = 1'b0;
          pbad_d  = 1'b0;
        end
      end
      RX_BUSY: begin
        if (bit_tick_i) begin
          if (slot_q == '0) begin
            // Start bit re-check: a high line means a glitch.
            if (line_i) state_d = RX_IDLE;
            else        slot_d  = slot_q + SW'(1);
          end else if (slot_q <= LAST_DATA) begin
            shift_d = {line_i, shift_q[DATA_BITS-1:1]};
            acc_d   = acc_q ^ line_i;
            slot_d  = slot_q + SW'(1);
          end else if (slot_q == PAR_SLOT) begin
            pbad_d  = line_i ^ acc_q;
            slot_d  = slot_q + SW'(1);
          end else begin
            // Stop slot: publish everything at once.
            pub_w   = 1'b1;
            data_d  = shift_q;
            perr_d  = pbad_q;
            ferr_d  = ~line_i;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      slot_q  <= '0;
      shift_q <= '0;
      acc_q   <= 1'b0;
      pbad_q  <= 1'b0;
      prev_q  <= 1'b1;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
      pbad_q  <= pbad_d;
      prev_q  <= prev_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign start_o   = start_w;
  assign busy_o    = (state_q == RX_BUSY);
  assign pub_o     = pub_w;
  assign data_o    = data_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rx_line,
  input  logic                 rd_ack,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 byte_rdy
);

  logic line_s;
  logic start_w;
  logic busy_w;
  logic pub_w;
  logic bit_tick_w;
  logic rdy_q, rdy_d;

  uart_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_line),
    .q_o   (line_s)
  );

  uart_rx_bit_timer #(
    .OVS (OVS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .clear_i    (start_w),
    .run_i      (busy_w),
    .bit_tick_o (bit_tick_w)
  );

  uart_rx_frame #(
    .DATA_BITS (DATA_BITS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .line_i     (line_s),
    .bit_tick_i (bit_tick_w),
    .start_o    (start_w),
    .busy_o     (busy_w),
    .pub_o      (pub_w),
    .data_o     (rx_byte),
    .par_err_o  (par_err),
    .frm_err_o  (frm_err)
  );

  // Data-ready: a completing frame wins over an acknowledge.
  always_comb begin
    rdy_d = rdy_q;
    if (pub_w)       rdy_d = 1'b1;
    else if (rd_ack) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign byte_rdy = rdy_q;

endmodule

// File: rtl/uart_rx_sva.sv
module uart_rx_sva #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 os_tick,
  input logic                 rd_ack,
  input logic                 byte_rdy,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 par_err,
  input logic                 frm_err,
  input logic                 start_det,
  input logic                 bit_tick,
  input logic                 pub
);

  // R2: a start edge is only taken on a strobe, never while sampling bits.
  a_r2_start_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> os_tick);
  a_r2_start_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, bit_tick}));

  // R7: publication happens on a strobe, and data-ready rises only after it.
  a_r7_pub_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pub |-> (os_tick && bit_tick));
  a_r7_rdy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_rdy) |-> $past(pub));

  // R8: data-ready set, held and cleared.
  a_r8_pub_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pub |=> byte_rdy);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !pub) |=> !byte_rdy);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rdy && !rd_ack) |=> byte_rdy);

  // R9: results move only on a completing frame.
  a_r9_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pub |=> ($stable(rx_byte) && $stable(par_err) && $stable(frm_err)));

endmodule

bind uart_rx_core uart_rx_sva #(
  .DATA_BITS (DATA_BITS)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .os_tick   (os_tick),
  .rd_ack    (rd_ack),
  .byte_rdy  (byte_rdy),
  .rx_byte   (rx_byte),
  .par_err   (par_err),
  .frm_err   (frm_err),
  .start_det (start_w),
  .bit_tick  (bit_tick_w),
  .pub       (pub_w)
);

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;

  localparam int STB       = 4;          // clocks per 16x strobe
  localparam int BIT_CLKS  = 16 * STB;   // clocks per serial bit
  localparam int WD_LIMIT  = 150000;

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       rx_line;
  logic       rd_ack;
  logic [7:0] rx_byte;
  logic       par_err;
  logic       frm_err;
  logic       byte_rdy;

  int n_chk;
  int n_fail;
  int cyc;
  int phase;
  bit done;

  uart_rx_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .rx_line  (rx_line),
    .rd_ack   (rd_ack),
    .rx_byte  (rx_byte),
    .par_err  (par_err),
    .frm_err  (frm_err),
    .byte_rdy (byte_rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Strobe generator, driven away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      phase   <= 0;
      os_tick <= 1'b0;
    end else begin
      phase   <= (phase == STB - 1) ? 0 : phase + 1;
      os_tick <= (phase == STB - 1);
    end
  end

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] d, input bit flip_par,
                           input logic stop_b, input bit keep_low, input int gap);
    logic pbit;
    pbit = even_par(d) ^ flip_par;
    pulse_ack();
    chk(byte_rdy == 1'b0, "R8 ack clears ready", byte_rdy, 0);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(pbit);
    chk(byte_rdy == 1'b0, "R7 nothing before stop sample", byte_rdy, 0);
    drive_bit(stop_b);
    chk(byte_rdy == 1'b1, "R7 ready after stop sample", byte_rdy, 1);
    chk(rx_byte == d, "R4 byte LSB first", rx_byte, d);
    chk(par_err == flip_par, "R5 parity flag", par_err, flip_par);
    chk(frm_err == !stop_b, "R6 framing flag", frm_err, !stop_b);
    if (keep_low) begin
      pulse_ack();
      repeat (12 * BIT_CLKS) @(negedge clk);
      chk(byte_rdy == 1'b0, "R2 steady low starts nothing", byte_rdy, 0);
    end
    rx_line = 1'b1;
    repeat (gap * STB) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; rx_line = 1'b1; rd_ack = 1'b0;
    seed_v = $urandom(32'h5EED_0C1);
    repeat (5) @(negedge clk);
    chk(byte_rdy == 1'b0 && rx_byte == 8'h00, "R1 reset ready/byte", {byte_rdy, rx_byte}, 0);
    chk(par_err == 1'b0 && frm_err == 1'b0, "R1 reset flags", {par_err, frm_err}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(byte_rdy == 1'b0 && rx_byte == 8'h00, "R1 idle after reset", {byte_rdy, rx_byte}, 0);

    // R5 directed parity values.
    run_frame(8'h52, 1'b0, 1'b1, 1'b0, 6);
    run_frame(8'h53, 1'b0, 1'b1, 1'b0, 6);
    run_frame(8'h53, 1'b1, 1'b1, 1'b0, 6);

    // R3 glitch shorter than half a bit is dropped.
    rx_line = 1'b0;
    repeat (3 * STB) @(negedge clk);
    rx_line = 1'b1;
    repeat (14 * BIT_CLKS) @(negedge clk);
    chk(byte_rdy == 1'b1, "R3 glitch keeps ready", byte_rdy, 1);
    chk(rx_byte == 8'h53, "R3 glitch keeps byte", rx_byte, 8'h53);
    chk(par_err == 1'b1, "R3 glitch keeps flag", par_err, 1);

    // R9 acknowledge alone leaves results intact.
    pulse_ack();
    chk(byte_rdy == 1'b0, "R8 ack clears ready", byte_rdy, 0);
    chk(rx_byte == 8'h53, "R9 ack keeps byte", rx_byte, 8'h53);
    chk(par_err == 1'b1, "R9 ack keeps parity flag", par_err, 1);

    run_frame(8'h0F, 1'b0, 1'b1, 1'b0, 4);
    // R6 and R2: low stop bit, line then held low.
    run_frame(8'hA5, 1'b0, 1'b0, 1'b1, 4);
    run_frame(8'h00, 1'b0, 1'b1, 1'b0, 2);
    run_frame(8'hFF, 1'b1, 1'b0, 1'b0, 2);

    // Constrained random frames.
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      bit fp;
      logic sb;
      int gap;
      d   = 8'($urandom);
      fp  = ($urandom % 5) == 0;
      sb  = ($urandom % 6) != 0;
      gap = 2 + int'($urandom % 19);
      run_frame(d, fp, sb, 1'b0, gap);
    end

    finish_run();
  end

endmodule